// File: doc/BRIEF.md
# Multi-Chip Processor Bus Decoder

Up to four identical controller chips can hang on one shared processor address/data bus. Each chip has a 2-bit identity strapped on its pins. This block is the piece of each chip that decides whether a processor access belongs to it. When multi-chip operation is enabled, it compares an identity field of the address with the strap. A write that matches goes to the chip's local register file. A read that matches goes either to the local registers or to the boot-ROM chip select, depending on one extra address bit. Every other internal target (memory, PCI, device and DMA) is cut off.

When multi-chip operation is disabled, the target selection produced by the chip's normal decoder passes straight through this block. In that mode the register and boot-ROM outputs of the multi-chip path stay idle.

The block also drives three shared handshake wires: write-ready, valid-in and cache output-enable. Each wire is modelled as a value plus an output-enable, so that several chips can be wired together on it. On every assertion the chip drives the active level. After the assertion it drives a release level for exactly one cycle, then floats the wire. This behaviour applies in both modes. The chip that holds the boot device must be strapped to identity 3, because the processor's reset fetch address (0x1FC00000) has address bits [26:25] equal to 3 and bit 27 set.

Top module: `mc_bus_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `reg_stb_o`, `boot_cs_o`, `tgt_sel_o` and `hs_oe_o` are all zero. The multi-chip mode is left cleared.
- R2: In multi-chip mode, an access belongs to this chip only when address bits [26:25] equal the sampled identity. An access that does not match gives no `reg_stb_o` and no `boot_cs_o`.
- R3: A matching write (`acc_write_i`=1) raises `reg_stb_o` and `reg_we_o` one cycle after the access is presented, and `reg_off_o` equals address bits [11:0]. Address bit 27 does not affect a write, and a write never raises `boot_cs_o`.
- R4: A matching read with address bit 27 clear raises `reg_stb_o` one cycle later, with `reg_we_o`=0 and `reg_off_o` equal to address bits [11:0].
- R5: A matching read with address bit 27 set raises `boot_cs_o` one cycle later, and `reg_stb_o` stays low.
- R6: While multi-chip mode is set, `tgt_sel_o` is all zero, whatever `norm_sel_i` holds.
- R7: While multi-chip mode is clear, `tgt_sel_o` equals `norm_sel_i` one cycle later, and `reg_stb_o` and `boot_cs_o` stay low.
- R8: A qualified handshake request on line i raises `hs_oe_o[i]` in the next cycle, with `hs_val_o[i]`=0, the active level of all three lines. Line 0 is write-ready, line 1 is valid-in and line 2 is cache output-enable.
- R9: In the cycle after a qualified request ends, line i is still enabled and drives its release level: 0 on lines 0 and 2, 1 on line 1. In the cycle after that, `hs_oe_o[i]` is 0.
- R10: A handshake request is qualified only while a claimed access is presented. A claimed access is one with `acc_valid_i`=1 and either the mode clear or the identity matching. Any other request leaves `hs_oe_o` at zero.
- R11: The mode bit and the identity are sampled into registers. An access presented in the same cycle that the strap changes is still decoded with the old identity. The new identity applies from the next cycle.
- R12: The handshake lines behave as in R8 and R9 with the multi-chip mode clear as well as set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_multi_i | input | 1 | Multi-chip mode enable |
| cfg_id_i | input | 2 | Strapped chip identity |
| acc_valid_i | input | 1 | Processor access present |
| acc_write_i | input | 1 | Access is a write |
| acc_addr_i | input | 32 | Processor address |
| norm_sel_i | input | 4 | Target selection from the normal decoder |
| hs_req_i | input | 3 | Handshake assertion requests (0 write-ready, 1 valid-in, 2 cache OE) |
| reg_stb_o | output | 1 | Local register access strobe |
| reg_we_o | output | 1 | Local register write enable |
| reg_off_o | output | 12 | Local register offset |
| boot_cs_o | output | 1 | Boot-ROM chip select |
| tgt_sel_o | output | 4 | Gated internal target selection |
| hs_val_o | output | 3 | Handshake line values |
| hs_oe_o | output | 3 | Handshake line output enables |

## Verification
The hardest case to reach from the ports is the timing skew between the sampled strap and the access. An identity change and an access that matches the new identity are driven in the same cycle. The bench expects the old identity to win for that one cycle and the new identity to win in the next cycle. The release cycle of each shared line is reached by holding a claimed access while the request is pulsed. The bench then samples three successive cycles: active level, release level, and floating. It does this in both modes, and again with a non-matching access to show that the request is dropped.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  // Per-line handshake sequencer states
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_DRIVE = 2'd1,
    HS_REL   = 2'd2
  } hs_state_e;

  // Decoded routing of one access
  typedef struct packed {
    logic stb;
    logic we;
    logic boot;
  } route_t;

endpackage

// File: rtl/mcd_cfg_sync.sv
module mcd_cfg_sync #(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_i,
  input  logic [ID_W-1:0] id_i,
  output logic            mode_o,
  output logic [ID_W-1:0] id_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= 1'b0;
      id_o   <= '0;
    end else begin
      mode_o <= mode_i;
      id_o   <= id_i;
    end
  end

  // R1: mode stays cleared in the cycle after reset
  mode_after_rst_chk: assert property (@(posedge clk) rst |=> !mode_o);

endmodule

// File: rtl/mcd_addr_decode.sv
module mcd_addr_decode
  import mcd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ID_LSB  = 25,
  parameter int ID_W    = 2,
  parameter int SEL_BIT = 27,
  parameter int OFF_W   = 12,
  parameter int N_TGT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_q_i,
  input  logic [ID_W-1:0]   id_q_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [N_TGT-1:0]  norm_sel_i,
  output logic              claim_o,
  output logic              reg_stb_o,
  output logic              reg_we_o,
  output logic [OFF_W-1:0]  reg_off_o,
  output logic              boot_cs_o,
  output logic [N_TGT-1:0]  tgt_sel_o
);

  localparam int ID_MSB = ID_LSB + ID_W - 1;

  logic [ID_W-1:0] addr_id;
  logic            hit;
  logic            sel_hi;
  route_t          route_d;
  logic            unused_addr;

  assign addr_id     = acc_addr_i[ID_MSB:ID_LSB];
  assign sel_hi      = acc_addr_i[SEL_BIT];
  assign hit         = acc_valid_i && mode_q_i && (addr_id == id_q_i);
  assign claim_o     = acc_valid_i && (!mode_q_i || (addr_id == id_q_i));
  assign unused_addr = ^acc_addr_i;

  always_comb begin
    route_d = '0;
    if (hit) begin
      if (acc_write_i) begin
        route_d.stb = 1'b1;
        route_d.we  = 1'b1;
      end else if (sel_hi) begin
        route_d.boot = 1'b1;
      end else begin
        route_d.stb = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_stb_o <= 1'b0;
      reg_we_o  <= 1'b0;
      reg_off_o <= '0;
      boot_cs_o <= 1'b0;
      tgt_sel_o <= '0;
    end else begin
      reg_stb_o <= route_d.stb;
      reg_we_o  <= route_d.we;
      boot_cs_o <= route_d.boot;
      if (hit) begin
        reg_off_o <= acc_addr_i[OFF_W-1:0];
      end
      tgt_sel_o <= mode_q_i ? '0 : norm_sel_i;
    end
  end

  // R5: the boot select and the register strobe never fire together
  boot_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(boot_cs_o && reg_stb_o));

  // R3
  write_no_boot_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && acc_write_i) |=> !boot_cs_o);

  // R2
  mismatch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && mode_q_i && (addr_id != id_q_i)) |=> (!reg_stb_o && !boot_cs_o));

  // R6
  mode_blocks_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q_i |=> (tgt_sel_o == '0));

  // R7
  normal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_q_i |=> (!reg_stb_o && !boot_cs_o));

endmodule

// File: rtl/mcd_hs_line.sv
module mcd_hs_line
  import mcd_pkg::*;
#(
  parameter logic ACT_LVL = 1'b0,
  parameter logic REL_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic val_o,
  output logic oe_o
);

  hs_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= HS_IDLE;
      val_o <= REL_LVL;
      oe_o  <= 1'b0;
    end else if (req_i) begin
      st    <= HS_DRIVE;
      val_o <= ACT_LVL;
      oe_o  <= 1'b1;
    end else if (st == HS_DRIVE) begin
      st    <= HS_REL;
      val_o <= REL_LVL;
      oe_o  <= 1'b1;
    end else begin
      st    <= HS_IDLE;
      val_o <= REL_LVL;
      oe_o  <= 1'b0;
    end
  end

  // R8
  hs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (oe_o && val_o == ACT_LVL));

  // R9: one release cycle at the release level
  hs_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == HS_DRIVE && !req_i) |=> (oe_o && val_o == REL_LVL));

  // R9: then float
  hs_float_chk: assert property (@(posedge clk) disable iff (rst)
    (st == HS_REL && !req_i) |=> !oe_o);

endmodule

// File: rtl/mc_bus_decoder.sv
module mc_bus_decoder #(
  parameter int ADDR_W  = 32,
  parameter int ID_LSB  = 25,
  parameter int ID_W    = 2,
  parameter int SEL_BIT = 27,
  parameter int OFF_W   = 12,
  parameter int N_TGT   = 4,
  parameter int N_HS    = 3,
  parameter logic [N_HS-1:0] HS_ACT = '0,
  parameter logic [N_HS-1:0] HS_REL = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_multi_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [N_TGT-1:0]  norm_sel_i,
  input  logic [N_HS-1:0]   hs_req_i,
  output logic              reg_stb_o,
  output logic              reg_we_o,
  output logic [OFF_W-1:0]  reg_off_o,
  output logic              boot_cs_o,
  output logic [N_TGT-1:0]  tgt_sel_o,
  output logic [N_HS-1:0]   hs_val_o,
  output logic [N_HS-1:0]   hs_oe_o
);

  logic            mode_q;
  logic [ID_W-1:0] id_q;
  logic            claim;
  logic [N_HS-1:0] req_q;

  mcd_cfg_sync #(.ID_W(ID_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .mode_i (cfg_multi_i),
    .id_i   (cfg_id_i),
    .mode_o (mode_q),
    .id_o   (id_q)
  );

  mcd_addr_decode #(
    .ADDR_W  (ADDR_W),
    .ID_LSB  (ID_LSB),
    .ID_W    (ID_W),
    .SEL_BIT (SEL_BIT),
    .OFF_W   (OFF_W),
    .N_TGT   (N_TGT)
  ) u_dec (
    .clk         (clk),
    .rst         (rst),
    .mode_q_i    (mode_q),
    .id_q_i      (id_q),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_addr_i  (acc_addr_i),
    .norm_sel_i  (norm_sel_i),
    .claim_o     (claim),
    .reg_stb_o   (reg_stb_o),
    .reg_we_o    (reg_we_o),
    .reg_off_o   (reg_off_o),
    .boot_cs_o   (boot_cs_o),
    .tgt_sel_o   (tgt_sel_o)
  );

  // R10: requests count only during a claimed access
  assign req_q = claim ? hs_req_i : '0;

  for (genvar g = 0; g < N_HS; g++) begin : g_hs
    mcd_hs_line #(
      .ACT_LVL (HS_ACT[g]),
      .REL_LVL (HS_REL[g])
    ) u_line (
      .clk   (clk),
      .rst   (rst),
      .req_i (req_q[g]),
      .val_o (hs_val_o[g]),
      .oe_o  (hs_oe_o[g])
    );
  end

  // R10
  unclaimed_float_chk: assert property (@(posedge clk) disable iff (rst)
    (!claim && !$past(claim) && !$past(claim, 2)) |=> (hs_oe_o == '0));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (hs_oe_o == '0 && !reg_stb_o && !boot_cs_o && tgt_sel_o == '0));

endmodule

// File: tb/mc_bus_decoder_bench.sv
module mc_bus_decoder_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_multi;
  logic [1:0]  cfg_id;
  logic        acc_valid;
  logic        acc_write;
  logic [31:0] acc_addr;
  logic [3:0]  norm_sel;
  logic [2:0]  hs_req;
  logic        reg_stb;
  logic        reg_we;
  logic [11:0] reg_off;
  logic        boot_cs;
  logic [3:0]  tgt_sel;
  logic [2:0]  hs_val;
  logic [2:0]  hs_oe;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  mc_bus_decoder u_mc_bus_decoder (
    .clk         (clk),
    .rst         (rst),
    .cfg_multi_i (cfg_multi),
    .cfg_id_i    (cfg_id),
    .acc_valid_i (acc_valid),
    .acc_write_i (acc_write),
    .acc_addr_i  (acc_addr),
    .norm_sel_i  (norm_sel),
    .hs_req_i    (hs_req),
    .reg_stb_o   (reg_stb),
    .reg_we_o    (reg_we),
    .reg_off_o   (reg_off),
    .boot_cs_o   (boot_cs),
    .tgt_sel_o   (tgt_sel),
    .hs_val_o    (hs_val),
    .hs_oe_o     (hs_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply an access at a falling edge, then sample just after the next rising edge
  task automatic present(input logic wr, input logic [31:0] a, input logic [3:0] ns);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_addr  = a;
    norm_sel  = ns;
    @(posedge clk);
    #2;
  endtask

  task automatic idle_bus();
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
    hs_req    = '0;
  endtask

  task automatic set_cfg(input logic m, input logic [1:0] id);
    @(negedge clk);
    cfg_multi = m;
    cfg_id    = id;
    repeat (2) @(posedge clk);
  endtask

  function automatic logic [31:0] mk_addr(input logic b27, input logic [1:0] id, input logic [11:0] off);
    return {4'h0, b27, id, 13'h0, off};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reg_stb", {31'd0, reg_stb}, 32'd0);
    chk("R1 boot_cs", {31'd0, boot_cs}, 32'd0);
    chk("R1 tgt_sel", {28'd0, tgt_sel}, 32'd0);
    chk("R1 hs_oe", {29'd0, hs_oe}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    // mode left cleared: normal selection passes straight through
    present(1'b0, 32'h0, 4'b1010);
    chk("R1 mode cleared tgt", {28'd0, tgt_sel}, 32'hA);
    idle_bus();
  endtask

  task automatic t_match_write();
    set_cfg(1'b1, 2'd2);
    present(1'b1, mk_addr(1'b0, 2'd2, 12'hABC), 4'hF);
    chk("R3 stb", {31'd0, reg_stb}, 32'd1);
    chk("R3 we", {31'd0, reg_we}, 32'd1);
    chk("R3 off", {20'd0, reg_off}, 32'hABC);
    chk("R6 tgt blocked", {28'd0, tgt_sel}, 32'd0);
    present(1'b1, mk_addr(1'b1, 2'd2, 12'h05A), 4'hF);
    chk("R3 b27 write stb", {31'd0, reg_stb}, 32'd1);
    chk("R3 b27 write no boot", {31'd0, boot_cs}, 32'd0);
    chk("R3 b27 write off", {20'd0, reg_off}, 32'h05A);
    idle_bus();
  endtask

  task automatic t_match_read();
    set_cfg(1'b1, 2'd2);
    present(1'b0, mk_addr(1'b0, 2'd2, 12'h123), 4'h3);
    chk("R4 stb", {31'd0, reg_stb}, 32'd1);
    chk("R4 we", {31'd0, reg_we}, 32'd0);
    chk("R4 off", {20'd0, reg_off}, 32'h123);
    chk("R4 no boot", {31'd0, boot_cs}, 32'd0);
    idle_bus();
  endtask

  task automatic t_boot_read();
    set_cfg(1'b1, 2'd3);
    present(1'b0, 32'h1FC0_0000, 4'h0);
    chk("R5 boot_cs", {31'd0, boot_cs}, 32'd1);
    chk("R5 no stb", {31'd0, reg_stb}, 32'd0);
    idle_bus();
    @(posedge clk);
    #2;
    chk("R5 boot_cs drops", {31'd0, boot_cs}, 32'd0);
  endtask

  task automatic t_mismatch();
    set_cfg(1'b1, 2'd1);
    for (int i = 0; i < 4; i++) begin
      present(1'b0, mk_addr(1'b0, i[1:0], 12'h010), 4'h0);
      chk("R2 read id sweep", {31'd0, reg_stb}, (i == 1) ? 32'd1 : 32'd0);
      present(1'b0, mk_addr(1'b1, i[1:0], 12'h010), 4'h0);
      chk("R2 boot id sweep", {31'd0, boot_cs}, (i == 1) ? 32'd1 : 32'd0);
    end
    idle_bus();
  endtask

  task automatic t_cfg_timing();
    set_cfg(1'b1, 2'd1);
    @(negedge clk);
    cfg_id    = 2'd2;
    acc_valid = 1'b1;
    acc_write = 1'b1;
    acc_addr  = mk_addr(1'b0, 2'd2, 12'h0F0);
    @(posedge clk);
    #2;
    chk("R11 old id still used", {31'd0, reg_stb}, 32'd0);
    @(posedge clk);
    #2;
    chk("R11 new id applies", {31'd0, reg_stb}, 32'd1);
    idle_bus();
  endtask

  task automatic t_normal();
    set_cfg(1'b0, 2'd0);
    present(1'b1, mk_addr(1'b0, 2'd0, 12'h001), 4'b0101);
    chk("R7 tgt pass", {28'd0, tgt_sel}, 32'h5);
    chk("R7 no stb", {31'd0, reg_stb}, 32'd0);
    present(1'b0, 32'h1FC0_0000, 4'b1000);
    chk("R7 no boot", {31'd0, boot_cs}, 32'd0);
    chk("R7 tgt pass 2", {28'd0, tgt_sel}, 32'h8);
    idle_bus();
  endtask

  task automatic t_hs(input logic m);
    set_cfg(m, 2'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      acc_valid = 1'b1;
      acc_write = 1'b0;
      acc_addr  = mk_addr(1'b0, 2'd0, 12'h000);
      hs_req    = 3'b001 << i;
      @(posedge clk);
      #2;
      chk(m ? "R8 drive oe" : "R12 drive oe", {31'd0, hs_oe[i]}, 32'd1);
      chk(m ? "R8 drive lvl" : "R12 drive lvl", {31'd0, hs_val[i]}, 32'd0);
      @(negedge clk);
      hs_req = '0;
      @(posedge clk);
      #2;
      chk(m ? "R9 release oe" : "R12 release oe", {31'd0, hs_oe[i]}, 32'd1);
      chk(m ? "R9 release lvl" : "R12 release lvl", {31'd0, hs_val[i]}, (i == 1) ? 32'd1 : 32'd0);
      @(posedge clk);
      #2;
      chk(m ? "R9 float" : "R12 float", {29'd0, hs_oe}, 32'd0);
      idle_bus();
    end
  endtask

  task automatic t_hs_gate();
    set_cfg(1'b1, 2'd0);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr  = mk_addr(1'b0, 2'd3, 12'h000);
    hs_req    = 3'b111;
    @(posedge clk);
    #2;
    chk("R10 mismatch no drive", {29'd0, hs_oe}, 32'd0);
    @(negedge clk);
    acc_valid = 1'b0;
    acc_addr  = mk_addr(1'b0, 2'd0, 12'h000);
    @(posedge clk);
    #2;
    chk("R10 no access no drive", {29'd0, hs_oe}, 32'd0);
    idle_bus();
  endtask

  initial begin
    rst       = 1'b1;
    cfg_multi = 1'b0;
    cfg_id    = '0;
    acc_valid = 1'b0;
    acc_write = 1'b0;
    acc_addr  = '0;
    norm_sel  = '0;
    hs_req    = '0;
    t_reset();
    t_match_write();
    t_match_read();
    t_boot_read();
    t_mismatch();
    t_cfg_timing();
    t_normal();
    t_hs(1'b1);
    t_hs(1'b0);
    t_hs_gate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule